// File: doc/BRIEF.md
# Frequency-Safety Watchdog with Selection Reload

This block protects a clock synthesizer against a frequency setting that leaves the system hung. Before host software changes the frequency in a risky way, it sets an arm bit and then writes a count depth. The depth write starts a down-counter that steps once per 250 ms tick. Software has to keep rewriting the depth to hold the counter away from zero. If the counter reaches zero, the block pulls an active-low system reset output low for a fixed number of clock cycles. It also puts the frequency-selection state back to a known-good code and turns off direct multiplier/divider programming, so the output frequency is taken from the table again.

The reload source depends on one select input. When the select is low, the block reloads the code that was latched from the hardware strap pins at power-on. When the select is high, it reloads a programmable safe code. The block keeps both the active 5-bit frequency selection and the direct-programming flag, so software writes to these pass through it.

Top module: `freq_guard_wdt`

## Requirements
- R1: After reset the block shows these values. The selection output equals the strap code. The direct-programming flag is 0. The arm readback is 0. The depth readback is 8. The timeout flag is 0. The reset output is 1.
- R2: A depth write while the arm bit is 0 only stores the value. The depth readback shows it, and later ticks neither change it nor cause a timeout.
- R3: A depth write while the arm bit is 1 starts counting from the written value. Each tick lowers the count by one, and the depth readback shows the live count. A count of 0 or 1 expires on the next tick.
- R4: The arm readback is 1 while counting and becomes 0 in the cycle the count expires.
- R5: The timeout flag goes to 1 on expiry. A later arming depth write clears it.
- R6: On expiry with the safe-select input at 0, the frequency selection becomes the strap code one cycle later.
- R7: On expiry with the safe-select input at 1, the frequency selection becomes the safe code. The safe code is 5'b00010 after reset and can be changed by a write.
- R8: On expiry the direct multiplier/divider programming flag is cleared.
- R9: The reset output goes low in the cycle after the timeout flag is set. It stays low for exactly 16 clock cycles and then returns to 1.
- R10: A depth write while counting reloads the count with the written value.
- R11: Writing 0 to the arm bit while counting stops the count. No timeout follows. The depth readback then shows the stored depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse every 250 ms |
| hw_sel | input | 5 | Frequency code latched from strap pins at power-on |
| use_safe | input | 1 | Reload source on expiry: 0 strap code, 1 safe code |
| arm_wr | input | 1 | Write strobe for the arm bit |
| arm_wdata | input | 1 | Arm bit value |
| depth_wr | input | 1 | Write strobe for the count depth |
| depth_wdata | input | 7 | Count depth, 250 ms per unit |
| safe_wr | input | 1 | Write strobe for the safe code |
| safe_wdata | input | 5 | Safe frequency code |
| sel_wr | input | 1 | Write strobe for the frequency selection |
| sel_wdata | input | 5 | Software frequency selection |
| mn_wr | input | 1 | Write strobe for the direct-programming flag |
| mn_wdata | input | 1 | Direct-programming flag value |
| freq_sel | output | 5 | Active frequency selection |
| mn_en | output | 1 | Direct multiplier/divider programming enabled |
| arm_rd | output | 1 | Arm bit readback |
| depth_rd | output | 7 | Live count while counting, otherwise the stored depth |
| timeout_flag | output | 1 | Set on expiry, cleared on restart |
| sys_rst_n | output | 1 | Active-low system reset pulse |

## Verification
The assertions assume three things about the inputs. First, the tick is a single-cycle pulse. Second, an arm write and a depth write never land in the same cycle as an expiring tick. Third, the frequency-select and direct-programming write strobes stay quiet in the cycle that follows expiry. The bench drives each strobe and each tick as a separate one-cycle pulse on the falling clock edge. It keeps software writes apart from expiring ticks, so every case it runs stays within these assumptions.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic {
    RELOAD_STRAP = 1'b0,
    RELOAD_SAFE  = 1'b1
  } reload_src_e;
endpackage

// File: rtl/fg_count.sv
module fg_count #(
  parameter int DW        = 7,
  parameter int DEF_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          arm_wr,
  input  logic          arm_wdata,
  input  logic          depth_wr,
  input  logic [DW-1:0] depth_wdata,
  output logic          arm_q,
  output logic          counting,
  output logic [DW-1:0] depth_view,
  output logic          flag_q,
  output logic          expire_q
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] depth_q;
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q    <= 1'b0;
      counting <= 1'b0;
      depth_q  <= DW'(DEF_DEPTH);
      cnt_q    <= '0;
      flag_q   <= 1'b0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (arm_wr) begin
        arm_q <= arm_wdata;
        if (!arm_wdata) counting <= 1'b0;
      end
      if (depth_wr) begin
        depth_q <= depth_wdata;
        if (arm_q) begin
          cnt_q    <= depth_wdata;
          counting <= 1'b1;
          flag_q   <= 1'b0;
        end
      end else if (tick && counting) begin
        if (cnt_q <= ONE) begin
          cnt_q    <= '0;
          counting <= 1'b0;
          arm_q    <= 1'b0;
          flag_q   <= 1'b1;
          expire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  assign depth_view = counting ? cnt_q : depth_q;
endmodule

// File: rtl/fg_sel.sv
module fg_sel
  import fg_pkg::*;
#(
  parameter int          SW       = 5,
  parameter logic [SW-1:0] DEF_SAFE = SW'(2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          expire,
  input  logic [SW-1:0] hw_sel,
  input  logic          use_safe,
  input  logic          safe_wr,
  input  logic [SW-1:0] safe_wdata,
  input  logic          sel_wr,
  input  logic [SW-1:0] sel_wdata,
  input  logic          mn_wr,
  input  logic          mn_wdata,
  output logic [SW-1:0] freq_sel,
  output logic          mn_en
);
  logic [SW-1:0] safe_q;
  reload_src_e   src;

  assign src = use_safe ? RELOAD_SAFE : RELOAD_STRAP;

  always_ff @(posedge clk) begin
    if (rst) begin
      safe_q   <= DEF_SAFE;
      freq_sel <= hw_sel;
      mn_en    <= 1'b0;
    end else begin
      if (safe_wr) safe_q <= safe_wdata;
      if (expire) begin
        freq_sel <= (src == RELOAD_SAFE) ? safe_q : hw_sel;
        mn_en    <= 1'b0;
      end else begin
        if (sel_wr) freq_sel <= sel_wdata;
        if (mn_wr)  mn_en    <= mn_wdata;
      end
    end
  end
endmodule

// File: rtl/fg_rstgen.sv
module fg_rstgen #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  output logic rst_n_o
);
  localparam int HW = (HOLD < 2) ? 1 : $clog2(HOLD);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_n_o <= 1'b1;
      hold_q  <= '0;
    end else if (expire) begin
      rst_n_o <= 1'b0;
      hold_q  <= HW'(HOLD - 1);
    end else if (hold_q != '0) begin
      hold_q <= hold_q - HW'(1);
    end else begin
      rst_n_o <= 1'b1;
    end
  end
endmodule

// File: rtl/freq_guard_wdt.sv
module freq_guard_wdt #(
  parameter int            DW        = 7,
  parameter int            SW        = 5,
  parameter int            HOLD      = 16,
  parameter int            DEF_DEPTH = 8,
  parameter logic [SW-1:0] DEF_SAFE  = 5'b00010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [SW-1:0] hw_sel,
  input  logic          use_safe,
  input  logic          arm_wr,
  input  logic          arm_wdata,
  input  logic          depth_wr,
  input  logic [DW-1:0] depth_wdata,
  input  logic          safe_wr,
  input  logic [SW-1:0] safe_wdata,
  input  logic          sel_wr,
  input  logic [SW-1:0] sel_wdata,
  input  logic          mn_wr,
  input  logic          mn_wdata,
  output logic [SW-1:0] freq_sel,
  output logic          mn_en,
  output logic          arm_rd,
  output logic [DW-1:0] depth_rd,
  output logic          timeout_flag,
  output logic          sys_rst_n
);
  logic counting;
  logic expire;

  fg_count #(.DW(DW), .DEF_DEPTH(DEF_DEPTH)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick),
    .arm_wr(arm_wr), .arm_wdata(arm_wdata),
    .depth_wr(depth_wr), .depth_wdata(depth_wdata),
    .arm_q(arm_rd), .counting(counting), .depth_view(depth_rd),
    .flag_q(timeout_flag), .expire_q(expire)
  );

  fg_sel #(.SW(SW), .DEF_SAFE(DEF_SAFE)) u_sel (
    .clk(clk), .rst(rst), .expire(expire),
    .hw_sel(hw_sel), .use_safe(use_safe),
    .safe_wr(safe_wr), .safe_wdata(safe_wdata),
    .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .mn_wr(mn_wr), .mn_wdata(mn_wdata),
    .freq_sel(freq_sel), .mn_en(mn_en)
  );

  fg_rstgen #(.HOLD(HOLD)) u_rst (
    .clk(clk), .rst(rst), .expire(expire), .rst_n_o(sys_rst_n)
  );
endmodule

// File: rtl/fg_chk.sv
module fg_chk #(
  parameter int DW   = 7,
  parameter int SW   = 5,
  parameter int HOLD = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          arm_wr,
  input logic          depth_wr,
  input logic          sel_wr,
  input logic          use_safe,
  input logic [SW-1:0] hw_sel,
  input logic [SW-1:0] freq_sel,
  input logic          mn_en,
  input logic          arm_rd,
  input logic [DW-1:0] depth_rd,
  input logic          timeout_flag,
  input logic          sys_rst_n,
  input logic          counting
);
  localparam int LW = $clog2(HOLD + 2);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)             low_cnt <= '0;
    else if (!sys_rst_n) low_cnt <= low_cnt + LW'(1);
    else                 low_cnt <= '0;
  end

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (counting && tick && !depth_wr && !arm_wr && depth_rd > DW'(1))
      |=> (depth_rd == $past(depth_rd) - DW'(1)));

  // R4
  arm_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_flag) |-> !arm_rd);

  // R5
  flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_flag) |-> $past(counting));

  // R6
  strap_reload_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(timeout_flag) && !use_safe && !sel_wr) |=> (freq_sel == $past(hw_sel)));

  // R8
  mn_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst_n) |-> !mn_en);

  // R9
  rst_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_flag) |=> !sys_rst_n);

  // R9
  rst_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_n) |-> (low_cnt == LW'(HOLD)));
endmodule

bind freq_guard_wdt fg_chk #(.DW(DW), .SW(SW), .HOLD(HOLD)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .arm_wr(arm_wr), .depth_wr(depth_wr),
  .sel_wr(sel_wr), .use_safe(use_safe), .hw_sel(hw_sel), .freq_sel(freq_sel),
  .mn_en(mn_en), .arm_rd(arm_rd), .depth_rd(depth_rd),
  .timeout_flag(timeout_flag), .sys_rst_n(sys_rst_n), .counting(counting)
);

// File: tb/sim_freq_guard_wdt.sv
`timescale 1ns/1ps
module sim_freq_guard_wdt;
  localparam logic [4:0] STRAP = 5'b10101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic use_safe = 1'b0;
  logic arm_wr = 1'b0, arm_wdata = 1'b0;
  logic depth_wr = 1'b0;
  logic [6:0] depth_wdata = '0;
  logic safe_wr = 1'b0;
  logic [4:0] safe_wdata = '0;
  logic sel_wr = 1'b0;
  logic [4:0] sel_wdata = '0;
  logic mn_wr = 1'b0, mn_wdata = 1'b0;
  logic [4:0] freq_sel;
  logic mn_en, arm_rd, timeout_flag, sys_rst_n;
  logic [6:0] depth_rd;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  freq_guard_wdt u0 (
    .clk(clk), .rst(rst), .tick(tick), .hw_sel(STRAP), .use_safe(use_safe),
    .arm_wr(arm_wr), .arm_wdata(arm_wdata),
    .depth_wr(depth_wr), .depth_wdata(depth_wdata),
    .safe_wr(safe_wr), .safe_wdata(safe_wdata),
    .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .mn_wr(mn_wr), .mn_wdata(mn_wdata),
    .freq_sel(freq_sel), .mn_en(mn_en), .arm_rd(arm_rd),
    .depth_rd(depth_rd), .timeout_flag(timeout_flag), .sys_rst_n(sys_rst_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_arm(input logic v);
    @(negedge clk); arm_wr = 1'b1; arm_wdata = v;
    @(negedge clk); arm_wr = 1'b0;
  endtask

  task automatic wr_depth(input logic [6:0] v);
    @(negedge clk); depth_wr = 1'b1; depth_wdata = v;
    @(negedge clk); depth_wr = 1'b0;
  endtask

  task automatic wr_safe(input logic [4:0] v);
    @(negedge clk); safe_wr = 1'b1; safe_wdata = v;
    @(negedge clk); safe_wr = 1'b0;
  endtask

  task automatic wr_sel(input logic [4:0] v);
    @(negedge clk); sel_wr = 1'b1; sel_wdata = v;
    @(negedge clk); sel_wr = 1'b0;
  endtask

  task automatic wr_mn(input logic v);
    @(negedge clk); mn_wr = 1'b1; mn_wdata = v;
    @(negedge clk); mn_wr = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  // After the expiring tick: reset low for 16 cycles, then high (R9)
  task automatic watch_reset(input logic [4:0] exp_sel, input string req);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      check("R9 reset low", sys_rst_n, 0);
      if (i == 0) begin
        check(req, freq_sel, exp_sel);
        check("R8 mn cleared", mn_en, 0);
      end
    end
    @(negedge clk);
    check("R9 reset released", sys_rst_n, 1);
  endtask

  task automatic t_reset();
    check("R1 freq_sel", freq_sel, STRAP);
    check("R1 mn_en", mn_en, 0);
    check("R1 arm_rd", arm_rd, 0);
    check("R1 depth_rd", depth_rd, 8);
    check("R1 flag", timeout_flag, 0);
    check("R1 sys_rst_n", sys_rst_n, 1);
  endtask

  task automatic t_idle_load();
    wr_depth(7'd5);
    check("R2 stored", depth_rd, 5);
    repeat (3) pulse_tick();
    check("R2 no count", depth_rd, 5);
    check("R2 no timeout", timeout_flag, 0);
    check("R2 no reset", sys_rst_n, 1);
  endtask

  task automatic t_arm_count();
    wr_arm(1'b1);
    check("R4 armed", arm_rd, 1);
    wr_depth(7'd4);
    check("R3 start", depth_rd, 4);
    pulse_tick();
    check("R3 step1", depth_rd, 3);
    pulse_tick();
    check("R3 step2", depth_rd, 2);
    check("R4 still armed", arm_rd, 1);
  endtask

  task automatic t_refresh();
    wr_depth(7'd6);
    check("R10 reload", depth_rd, 6);
    pulse_tick();
    check("R10 counts on", depth_rd, 5);
  endtask

  task automatic t_disarm();
    wr_arm(1'b0);
    check("R11 arm off", arm_rd, 0);
    check("R11 stored depth", depth_rd, 6);
    repeat (8) pulse_tick();
    check("R11 no timeout", timeout_flag, 0);
    check("R11 no reset", sys_rst_n, 1);
  endtask

  task automatic t_expire_strap();
    use_safe = 1'b0;
    wr_sel(5'd7);
    wr_mn(1'b1);
    check("R6 sw sel", freq_sel, 7);
    check("R8 mn set", mn_en, 1);
    wr_arm(1'b1);
    wr_depth(7'd2);
    pulse_tick();
    check("R9 no early reset", sys_rst_n, 1);
    pulse_tick();
    check("R5 flag set", timeout_flag, 1);
    check("R4 arm dropped", arm_rd, 0);
    check("R9 reset not yet", sys_rst_n, 1);
    watch_reset(STRAP, "R6 strap reload");
  endtask

  task automatic t_expire_safe_default();
    use_safe = 1'b1;
    wr_sel(5'd3);
    wr_arm(1'b1);
    check("R5 flag held", timeout_flag, 1);
    wr_depth(7'd1);
    check("R5 flag cleared", timeout_flag, 0);
    pulse_tick();
    check("R3 one expires", timeout_flag, 1);
    watch_reset(5'b00010, "R7 default safe");
  endtask

  task automatic t_expire_safe_prog();
    use_safe = 1'b1;
    wr_safe(5'b11000);
    check("R7 no early reload", freq_sel, 5'b00010);
    wr_arm(1'b1);
    wr_depth(7'd0);
    pulse_tick();
    check("R3 zero expires", timeout_flag, 1);
    watch_reset(5'b11000, "R7 programmed safe");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle_load();
    t_arm_count();
    t_refresh();
    t_disarm();
    t_expire_strap();
    t_expire_safe_default();
    t_expire_safe_prog();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule